// File: doc/BRIEF.md
# Dual-Pulse Up/Down Counter with Cascade Outputs

This block is a presettable binary counter with no direction pin. It has two count inputs, one for counting up and one for counting down. The direction of each step is set by which of the two inputs receives a pulse while the other rests high. Both inputs are ordinary level signals on a single system clock. The block samples them into registers and finds their rising edges inside, so all state bits change together on one clock edge.

The counter also offers three more controls. A parallel preset is loaded while an active-low load input is held. A clear input forces zero and wins over everything else. Two active-low terminal outputs follow the count input that reaches the end of the range. The carry output is low while the up input is low at the top value. The borrow output is low while the down input is low at zero. Each stage passes on a pulse as wide as the one it received. A wider counter is built by wiring carry to the next stage's up input and borrow to the next stage's down input, with no extra logic.

Top module: `dual_pulse_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count goes to 0. Afterwards, with both count inputs high, `carry_n` and `borrow_n` read 1.
- R2: A rising edge on `up_in` counts the value up by one, modulo 2^WIDTH. The edge is a sample of 1 at a clock edge after a sample of 0 at the previous edge. The new value is visible after that clock edge.
- R3: A rising edge on `dn_in` counts the value down by one, modulo 2^WIDTH, with the same timing as R2.
- R4: Holding a count input steady at 0 or at 1, for any number of cycles, leaves the value unchanged.
- R5: If `up_in` and `dn_in` both show a rising edge at the same clock edge, the value does not change.
- R6: While `load_n` is 0 (active low), the value takes `preset` at each clock edge, and any count edge at that edge is ignored.
- R7: While `clr` is 1 (active high), the value becomes 0 at the clock edge. This overrides both load and counting.
- R8: `carry_n` is 0 exactly while `up_in` is 0 and the value is all ones (15 at WIDTH=4). Otherwise it is 1.
- R9: `borrow_n` is 0 exactly while `dn_in` is 0 and the value is 0. Otherwise it is 1.
- R10: Two stages chained carry-to-up and borrow-to-down count as one counter of twice the width, in both directions, through wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Clear to zero, active high, highest priority |
| load_n | input | 1 | Parallel load, active low |
| preset | input | WIDTH | Value taken while loading |
| up_in | input | 1 | Up count input, counts on its rising edge |
| dn_in | input | 1 | Down count input, counts on its rising edge |
| value | output | WIDTH | Current count |
| carry_n | output | 1 | Low while up_in is low at the top value |
| borrow_n | output | 1 | Low while dn_in is low at zero |

## Verification
The hardest situation to reach is a carry or borrow crossing into a second stage. For that, the lower stage must sit at its terminal value while its count input is held low for a full clock. Only then does the upper stage sample a low level before the release edge. The bench chains two instances and drives several hundred full pulses up and then down through the eight-bit range. It compares the joined value against a modulo-256 count after every pulse. Edges that arrive together with load or clear come from setting both inputs in the same driving slot.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    // channel positions inside the sampled count-input vector
    localparam int CH_UP  = 0;
    localparam int CH_DN  = 1;
    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } cnt_op_e;

    typedef struct packed {
        logic dn;
        logic up;
    } pulse_pair_t;

    // priority: clear, then load, then a single-direction count
    function automatic cnt_op_e pick_op(input logic clr, input logic load_n,
                                        input pulse_pair_t rise);
        cnt_op_e op;
        if (clr)                       op = OP_CLEAR;
        else if (!load_n)              op = OP_LOAD;
        else if (rise.up && !rise.dn)  op = OP_INC;
        else if (rise.dn && !rise.up)  op = OP_DEC;
        else                           op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/dpc_edge_detect.sv
module dpc_edge_detect #(
    parameter int   NUM  = 2,
    parameter logic IDLE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] lvl,
    output logic [NUM-1:0] rise
);
    for (genvar g = 0; g < NUM; g++) begin : g_ch
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= IDLE;
            else     prev_q <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q;
    end
endmodule

// File: rtl/dpc_state_reg.sv
module dpc_state_reg
    import dpc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] state_q, state_d;

    always_comb begin
        case (op)
            OP_CLEAR: state_d = '0;
            OP_LOAD:  state_d = preset;
            OP_INC:   state_d = state_q + ONE;
            OP_DEC:   state_d = state_q - ONE;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign value = state_q;
endmodule

// File: rtl/dpc_terminal.sv
module dpc_terminal #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_top, at_zero;
    assign at_top  = (value == TOP);
    assign at_zero = (value == '0);

    // the terminal output follows the count input's low phase, so the pulse width passes on
    assign carry_n  = ~(at_top  & ~up_lvl);
    assign borrow_n = ~(at_zero & ~dn_lvl);
endmodule

// File: rtl/dual_pulse_counter.sv
module dual_pulse_counter
    import dpc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             up_in,
    input  logic             dn_in,
    output logic [WIDTH-1:0] value,
    output logic             carry_n,
    output logic             borrow_n
);
    logic [NUM_CH-1:0] lvl_vec;
    logic [NUM_CH-1:0] rise_vec;
    pulse_pair_t       rise_pair;
    cnt_op_e           op;

    assign lvl_vec[CH_UP] = up_in;
    assign lvl_vec[CH_DN] = dn_in;

    dpc_edge_detect #(.NUM(NUM_CH), .IDLE(1'b1)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_vec),
        .rise (rise_vec)
    );

    assign rise_pair.up = rise_vec[CH_UP];
    assign rise_pair.dn = rise_vec[CH_DN];
    assign op = pick_op(clr, load_n, rise_pair);

    dpc_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .preset (preset),
        .value  (value)
    );

    dpc_terminal #(.WIDTH(WIDTH)) u_term (
        .value    (value),
        .up_lvl   (up_in),
        .dn_lvl   (dn_in),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             load_n,
    input logic [WIDTH-1:0] preset,
    input logic             up_in,
    input logic             dn_in,
    input logic [WIDTH-1:0] value,
    input logic             carry_n,
    input logic             borrow_n,
    input logic             up_rise,
    input logic             dn_rise
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (value == '0));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && up_rise && !dn_rise) |=> (value == $past(value) + ONE));

    // R3
    dn_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && dn_rise && !up_rise) |=> (value == $past(value) - ONE));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && !up_rise && !dn_rise) |=> $stable(value));

    // R5
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && up_rise && dn_rise) |=> $stable(value));

    // R6
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> (value == $past(preset)));

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0));

    // R8
    carry_top_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> (value == TOP && !up_in));

    // R9
    borrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> (value == '0 && !dn_in));
endmodule

bind dual_pulse_counter dpc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load_n   (load_n),
    .preset   (preset),
    .up_in    (up_in),
    .dn_in    (dn_in),
    .value    (value),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .up_rise  (rise_vec[0]),
    .dn_rise  (rise_vec[1])
);

// File: tb/test_dual_pulse_counter.sv
module test_dual_pulse_counter;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic clk = 1'b0;
    logic rst, clr, load_n, up_in, dn_in, hi_load_n;
    logic [W-1:0] preset, hi_preset;
    logic [W-1:0] value, hi_value;
    logic carry_n, borrow_n, hi_carry_n, hi_borrow_n;

    int checks = 0;
    int fails  = 0;
    int exp    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pulse_counter #(.WIDTH(W)) i_dual_pulse_counter (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .preset(preset),
        .up_in(up_in), .dn_in(dn_in), .value(value),
        .carry_n(carry_n), .borrow_n(borrow_n)
    );

    dual_pulse_counter #(.WIDTH(W)) i_stage_hi (
        .clk(clk), .rst(rst), .clr(clr), .load_n(hi_load_n), .preset(hi_preset),
        .up_in(carry_n), .dn_in(borrow_n), .value(hi_value),
        .carry_n(hi_carry_n), .borrow_n(hi_borrow_n)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one full up pulse: low for a cycle, then high; checks carry in both phases and the new value
    task automatic pulse_up();
        @(negedge clk) up_in = 1'b0;
        #1 check("R8 carry low phase", int'(carry_n), (exp == M-1) ? 0 : 1);
        @(negedge clk) up_in = 1'b1;
        #1 check("R8 carry high phase", int'(carry_n), 1);
        @(negedge clk);
        exp = (exp + 1) % M;
        check("R2 up count", int'(value), exp);
    endtask

    task automatic pulse_dn();
        @(negedge clk) dn_in = 1'b0;
        #1 check("R9 borrow low phase", int'(borrow_n), (exp == 0) ? 0 : 1);
        @(negedge clk) dn_in = 1'b1;
        #1 check("R9 borrow high phase", int'(borrow_n), 1);
        @(negedge clk);
        exp = (exp + M - 1) % M;
        check("R3 down count", int'(value), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clr = 1'b0; load_n = 1'b1; hi_load_n = 1'b1;
        up_in = 1'b1; dn_in = 1'b1; preset = '0; hi_preset = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 reset value", int'(value), 0);
        check("R1 reset carry_n", int'(carry_n), 1);
        check("R1 reset borrow_n", int'(borrow_n), 1);

        // R2, R8: sweep up through one wrap
        for (int i = 0; i < M + 3; i++) pulse_up();
        // R3, R9: sweep down through one wrap
        for (int i = 0; i < M + 5; i++) pulse_dn();

        // R4: hold each count input low, then high, for several cycles
        @(negedge clk) up_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 up held low", int'(value), exp);
        up_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 up held high", int'(value), exp + 0 == exp ? (exp + 1) % M : 0);
        exp = (exp + 1) % M;
        @(negedge clk) dn_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 dn held low", int'(value), exp);
        dn_in = 1'b1;
        repeat (3) @(negedge clk);
        exp = (exp + M - 1) % M;
        check("R4 dn held high", int'(value), exp);

        // R5: simultaneous rising edges
        @(negedge clk) begin up_in = 1'b0; dn_in = 1'b0; end
        @(negedge clk) begin up_in = 1'b1; dn_in = 1'b1; end
        @(negedge clk);
        check("R5 both edges", int'(value), exp);

        // R6: every preset value, each with an up edge at the load edge
        for (int p = 0; p < M; p++) begin
            @(negedge clk) up_in = 1'b0;
            @(negedge clk) begin up_in = 1'b1; load_n = 1'b0; preset = W'(p); end
            @(negedge clk) load_n = 1'b1;
            exp = p;
            check("R6 load ignores edge", int'(value), exp);
        end
        pulse_up();

        // R7: clear with load low and a down edge
        @(negedge clk) dn_in = 1'b0;
        @(negedge clk) begin dn_in = 1'b1; clr = 1'b1; load_n = 1'b0; preset = 4'd9; end
        @(negedge clk) begin clr = 1'b0; load_n = 1'b1; end
        exp = 0;
        check("R7 clear wins", int'(value), 0);

        // R10: two-stage cascade, up then down across the full range
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        begin
            int total = 0;
            exp = 0;
            for (int i = 0; i < 260; i++) begin
                pulse_up();
                total = (total + 1) % 256;
                check("R10 cascade up", int'({hi_value, value}), total);
            end
            for (int i = 0; i < 270; i++) begin
                pulse_dn();
                total = (total + 255) % 256;
                check("R10 cascade down", int'({hi_value, value}), total);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule